// File: doc/BRIEF.md
# Two-Phase Memory-to-Memory Transfer Channel

This block is one DMA channel that copies data between two memory locations without processor involvement. Each transfer is a read bus cycle at the current source address followed by a write bus cycle at the current destination address. A holding register keeps the read data between the two cycles. Software sets up the source, destination, transfer count and a control word through a small register port, then sets the enable bit. The channel asks a bus arbiter for the bus, waits for the grant and runs the read/write pair as one locked unit. After each pair it drops the request for at least one cycle.

An access can be 1, 2 or 4 bytes. The configured bus width can be narrower than the access, or the address can be off its natural boundary. In either case the access is cut into several single-clock bus cycles. These pieces go out in ascending byte order, and read pieces are packed into the holding register before any write piece starts. An optional idle clock can be placed ahead of each pair. A transfer-end strobe can be switched on to mark every clock of the last pair, including that idle clock. The acknowledge output used by single-address schemes exists, but it never rises in this mode.

Top module: `dma2_chan`

## Requirements
- R1: Each transfer performs all read cycles at the source address first, then write cycles at the destination address. The written bytes equal the bytes read. Data travels right-justified on `busRdata`/`busWdata`, least significant byte at the lowest address.
- R2: `busReq` stays high from the cycle before the first read through the last write of a pair, with no gap. It is low in the cycle after the last write.
- R3: After `busReq` rises, no read or write strobe appears until `busGrant` is sampled high. The first read comes exactly one clock after that sample. When the idle bit is set, it comes two clocks after, and the clock in between carries `busReq` with neither strobe.
- R4: Piece sizing follows one rule. Each bus cycle moves the largest of 4, 2 or 1 bytes that fits within the bus width, fits within the bytes still left in the access, and is aligned to the piece's own address. Pieces run at ascending addresses. `busLen` encodes 0=1, 1=2, 2=4 bytes.
- R5: After each pair, each address moves by the access size according to its step code: 0 or 3 = fixed, 1 = increment, 2 = decrement. The updated values read back from the address registers.
- R6: With the end-enable bit set, `xferEnd` is high on the idle, read and write clocks of the final transfer and low on every other clock. With the bit clear, it is always low.
- R7: `dmaAck` is never high.
- R8: The count decrements once per completed pair. When it reaches zero, the enable bit clears and `done` rises. A control write that sets enable clears `done`.
- R9: While the enable bit is set, all register writes are ignored.
- R10: Setting enable with a count of zero raises no request and clears the enable bit by itself, leaving `done` low.
- R11: After reset, all registers read zero and `busReq`, `busRd`, `busWr`, `xferEnd` and `done` are low.
- R12: The register offsets are 0 = source, 1 = destination, 2 = count, 3 = control. The control bits are [0] enable, [1] end-enable, [3:2] source step, [5:4] destination step, [7:6] access size, [9:8] bus width, [10] idle and [11] done (read-only). The size and width codes are 0=1, 1=2, 2 or 3=4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| busReq | output | 1 | Bus request to the arbiter |
| busGrant | input | 1 | Bus grant from the arbiter |
| busAddr | output | ADDR_W | Bus cycle byte address |
| busRd | output | 1 | Read cycle strobe |
| busWr | output | 1 | Write cycle strobe |
| busLen | output | 2 | Piece length code |
| busWdata | output | 32 | Write data, right-justified |
| busRdata | input | 32 | Read data, right-justified, same cycle |
| xferEnd | output | 1 | Transfer-end strobe |
| dmaAck | output | 1 | Single-address acknowledge, held low |
| done | output | 1 | Final transfer completed |

## Verification
Timing is fixed by a few rules. Each strobe is due a fixed number of clocks after the grant sample: one clock for the first read, or two with the idle bit set. Each further piece follows one clock after the previous one. The release of `busReq` is due one clock after the last write. The bench drives the grant on a falling edge and then steps one falling edge per expected bus clock. At each step it compares the strobes, address, length, data and `xferEnd` against a behavioural model built from the piece rule and the step codes. Address, count and `done` results are read back on the first falling edge after the final write, when the register updates of the last pair have taken effect.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_GAP,
    ST_RD,
    ST_WR
  } chanState_t;

  typedef struct packed {
    logic selDst;
    logic clrOff;
    logic rdStep;
    logic wrStep;
    logic finish;
  } chanStrobe_t;

  function automatic logic [2:0] codeBytes(input logic [1:0] code);
    case (code)
      2'd0:    codeBytes = 3'd1;
      2'd1:    codeBytes = 3'd2;
      default: codeBytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dma2_ctrl.sv
module dma2_ctrl
  import dma2_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startOk,
  input  logic        pieceLast,
  input  logic        lastXfer,
  input  logic        idleEn,
  input  logic        endEn,
  input  logic        busGrant,
  output chanStrobe_t strobe,
  output logic        busReq,
  output logic        busRd,
  output logic        busWr,
  output logic        xferEnd
);
  chanState_t state, stateNx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNx;
  end

  always_comb begin
    stateNx = state;
    case (state)
      ST_IDLE: if (startOk) stateNx = ST_REQ;
      ST_REQ:  if (busGrant) stateNx = idleEn ? ST_GAP : ST_RD;
      ST_GAP:  stateNx = ST_RD;
      ST_RD:   if (pieceLast) stateNx = ST_WR;
      ST_WR:   if (pieceLast) stateNx = ST_IDLE;
      default: stateNx = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.selDst = (state == ST_WR);
    strobe.clrOff = (state == ST_REQ);
    strobe.rdStep = (state == ST_RD);
    strobe.wrStep = (state == ST_WR);
    strobe.finish = (state == ST_WR) && pieceLast;
  end

  assign busReq  = (state != ST_IDLE);
  assign busRd   = (state == ST_RD);
  assign busWr   = (state == ST_WR);
  assign xferEnd = endEn && lastXfer &&
                   (state == ST_GAP || state == ST_RD || state == ST_WR);

  // R3: reads begin only after a sampled grant
  p_rd_after_grant_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RD && $past(state) == ST_REQ) |-> $past(busGrant));

  // R3: idle clock is followed by the read
  p_gap_then_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP) |=> busRd);

  // R1: write phase follows the read phase directly
  p_wr_follows_rd_r1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busRd) |-> busWr);

  // R2: request held through the locked pair
  p_pair_locked_r2: assert property (@(posedge clk) disable iff (!rstN)
    busRd |=> busReq);
endmodule

// File: rtl/dma2_datapath.sv
module dma2_datapath
  import dma2_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  chanStrobe_t       strobe,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busLen,
  output logic [DATA_W-1:0] busWdata,
  output logic              startOk,
  output logic              pieceLast,
  output logic              lastXfer,
  output logic              idleEn,
  output logic              endEn,
  output logic              done
);
  localparam int unsigned LANES = DATA_W / 8;

  logic [ADDR_W-1:0] srcR, dstR, baseAddr, accStep;
  logic [CNT_W-1:0]  cntR;
  logic              enR, endEnR, idleR, doneR;
  logic [1:0]        srcModeR, dstModeR, sizeR, widthR;
  logic [DATA_W-1:0] holdR;
  logic [2:0]        byteOff, accBytes, busBytes, remain, pieceBytes;

  assign accBytes = codeBytes(sizeR);
  assign busBytes = codeBytes(widthR);
  assign accStep  = ADDR_W'(accBytes);
  assign baseAddr = strobe.selDst ? dstR : srcR;
  assign busAddr  = baseAddr + ADDR_W'(byteOff);
  assign remain   = accBytes - byteOff;

  always_comb begin
    if (busBytes >= 3'd4 && remain >= 3'd4 && busAddr[1:0] == 2'b00)
      pieceBytes = 3'd4;
    else if (busBytes >= 3'd2 && remain >= 3'd2 && busAddr[0] == 1'b0)
      pieceBytes = 3'd2;
    else
      pieceBytes = 3'd1;
  end

  assign pieceLast = (byteOff + pieceBytes) == accBytes;
  assign busLen    = (pieceBytes == 3'd4) ? 2'd2 : (pieceBytes == 3'd2) ? 2'd1 : 2'd0;
  assign busWdata  = holdR >> {byteOff, 3'b000};
  assign startOk   = enR && (cntR != '0);
  assign lastXfer  = (cntR == CNT_W'(1));
  assign idleEn    = idleR;
  assign endEn     = endEnR;
  assign done      = doneR;

  function automatic logic [ADDR_W-1:0] stepAddr(input logic [ADDR_W-1:0] a,
                                                 input logic [1:0] mode,
                                                 input logic [ADDR_W-1:0] inc);
    case (mode)
      2'd1:    stepAddr = a + inc;
      2'd2:    stepAddr = a - inc;
      default: stepAddr = a;
    endcase
  endfunction

  // offset walker and holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteOff <= '0;
      holdR   <= '0;
    end else begin
      if (strobe.clrOff) byteOff <= '0;
      else if (strobe.rdStep || strobe.wrStep)
        byteOff <= pieceLast ? 3'd0 : byteOff + pieceBytes;
      if (strobe.rdStep) begin
        for (int i = 0; i < LANES; i++) begin
          if (i < int'(pieceBytes) && (int'(byteOff) + i) < LANES)
            holdR[8*(int'(byteOff)+i) +: 8] <= busRdata[8*i +: 8];
        end
      end
    end
  end

  // programming registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcR <= '0; dstR <= '0; cntR <= '0;
      enR <= 1'b0; endEnR <= 1'b0; idleR <= 1'b0; doneR <= 1'b0;
      srcModeR <= '0; dstModeR <= '0; sizeR <= '0; widthR <= '0;
    end else if (regWe && !enR) begin
      case (regAddr)
        2'd0: srcR <= ADDR_W'(regWdata);
        2'd1: dstR <= ADDR_W'(regWdata);
        2'd2: cntR <= CNT_W'(regWdata);
        default: begin
          enR      <= regWdata[0];
          endEnR   <= regWdata[1];
          srcModeR <= regWdata[3:2];
          dstModeR <= regWdata[5:4];
          sizeR    <= regWdata[7:6];
          widthR   <= regWdata[9:8];
          idleR    <= regWdata[10];
          if (regWdata[0]) doneR <= 1'b0;
        end
      endcase
    end else if (strobe.finish) begin
      srcR <= stepAddr(srcR, srcModeR, accStep);
      dstR <= stepAddr(dstR, dstModeR, accStep);
      cntR <= cntR - CNT_W'(1);
      if (lastXfer) begin
        enR   <= 1'b0;
        doneR <= 1'b1;
      end
    end else if (enR && cntR == '0) begin
      enR <= 1'b0;
    end
  end

  always_comb begin
    case (regAddr)
      2'd0:    regRdata = 32'(srcR);
      2'd1:    regRdata = 32'(dstR);
      2'd2:    regRdata = 32'(cntR);
      default: regRdata = {20'd0, doneR, idleR, widthR, sizeR,
                           dstModeR, srcModeR, endEnR, enR};
    endcase
  end

  // R8: one decrement per completed pair
  p_count_dec_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> cntR == $past(cntR) - CNT_W'(1));

  // R8: final pair clears enable and raises done
  p_final_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && cntR == CNT_W'(1)) |=> (!enR && doneR));

  // R4: pieces stay inside the access
  p_off_inside_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdStep || strobe.wrStep) |-> (byteOff < accBytes));
endmodule

// File: rtl/dma2_chan.sv
module dma2_chan
  import dma2_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              busReq,
  input  logic              busGrant,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRd,
  output logic              busWr,
  output logic [1:0]        busLen,
  output logic [31:0]       busWdata,
  input  logic [31:0]       busRdata,
  output logic              xferEnd,
  output logic              dmaAck,
  output logic              done
);
  chanStrobe_t strobe;
  logic startOk, pieceLast, lastXfer, idleEn, endEn;

  dma2_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startOk(startOk), .pieceLast(pieceLast),
    .lastXfer(lastXfer), .idleEn(idleEn), .endEn(endEn), .busGrant(busGrant),
    .strobe(strobe), .busReq(busReq), .busRd(busRd), .busWr(busWr),
    .xferEnd(xferEnd)
  );

  dma2_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .strobe(strobe),
    .busRdata(busRdata), .busAddr(busAddr), .busLen(busLen),
    .busWdata(busWdata), .startOk(startOk), .pieceLast(pieceLast),
    .lastXfer(lastXfer), .idleEn(idleEn), .endEn(endEn), .done(done)
  );

  assign dmaAck = 1'b0;
endmodule

// File: tb/dma2_chan_test.sv
module dma2_chan_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        busReq, busRd, busWr, xferEnd, dmaAck, done;
  logic        busGrant = 1'b0;
  logic [31:0] busAddr, busWdata, busRdata;
  logic [1:0]  busLen;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma2_chan uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busReq(busReq),
    .busGrant(busGrant), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busLen(busLen), .busWdata(busWdata), .busRdata(busRdata),
    .xferEnd(xferEnd), .dmaAck(dmaAck), .done(done)
  );

  // memory model: combinational read, write at the clock edge
  always_comb
    busRdata = {mem[8'(busAddr + 3)], mem[8'(busAddr + 2)],
                mem[8'(busAddr + 1)], mem[8'(busAddr)]};

  always @(posedge clk) begin
    if (busWr) begin
      for (int i = 0; i < (1 << busLen); i++)
        mem[8'(busAddr + i)] <= busWdata[8*i +: 8];
    end
  end

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // R7: acknowledge never rises
  always @(negedge clk) if (rstN) chk(dmaAck == 1'b0, "R7", 32'(dmaAck), 0);

  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  function automatic int codeLen(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  function automatic int pieceLen(input int a, input int rem, input int bw);
    if (bw >= 4 && rem >= 4 && a % 4 == 0) return 4;
    if (bw >= 2 && rem >= 2 && a % 2 == 0) return 2;
    return 1;
  endfunction

  function automatic int stepBy(input int a, input logic [1:0] m, input int acc);
    if (m == 2'd1) return a + acc;
    if (m == 2'd2) return a - acc;
    return a;
  endfunction

  function automatic logic [1:0] lenCode(input int p);
    return (p == 4) ? 2'd2 : (p == 2) ? 2'd1 : 2'd0;
  endfunction

  task automatic runJob(input int s, input int d, input int cnt,
                        input logic [1:0] sm, input logic [1:0] dm,
                        input logic [1:0] sz, input logic [1:0] bw,
                        input bit idle, input bit ee, input bit poke,
                        input int gdly);
    int acc = codeLen(sz);
    int bb  = codeLen(bw);
    int sa  = s;
    int da  = d;
    logic [31:0] rd;
    writeReg(2'd0, 32'(s));
    writeReg(2'd1, 32'(d));
    writeReg(2'd2, 32'(cnt));
    writeReg(2'd3, {21'd0, idle, bw, sz, dm, sm, ee, 1'b1});
    chk(done == 1'b0, "R8 done cleared by start", 32'(done), 0);
    if (poke) writeReg(2'd0, 32'h000000E0);  // R9: must be ignored
    for (int k = 0; k < cnt; k++) begin
      bit expEnd = ee && (k == cnt - 1);
      int off;
      int wait_n = 0;
      while (!busReq) begin
        chk(xferEnd == 1'b0, "R6 low outside pair", 32'(xferEnd), 0);
        @(negedge clk);
        wait_n++;
        if (wait_n > 20) begin
          chk(1'b0, "R2 request never raised", 0, 1);
          return;
        end
      end
      for (int g = 0; g < gdly; g++) begin
        chk(!busRd && !busWr, "R3 no strobe before grant", {busRd, busWr}, 0);
        @(negedge clk);
      end
      busGrant = 1'b1;
      @(negedge clk);
      if (idle) begin
        chk(busReq && !busRd && !busWr, "R3 idle clock", {busReq, busRd, busWr}, 3'b100);
        chk(xferEnd == expEnd, "R6 idle clock", 32'(xferEnd), 32'(expEnd));
        @(negedge clk);
      end
      off = 0;
      while (off < acc) begin
        int p = pieceLen(sa + off, acc - off, bb);
        chk(busRd && !busWr, "R1 read phase", {busRd, busWr}, 2'b10);
        chk(busAddr == 32'(sa + off), "R4 read address", busAddr, 32'(sa + off));
        chk(busLen == lenCode(p), "R4 read length", 32'(busLen), 32'(lenCode(p)));
        chk(busReq, "R2 held in read", 32'(busReq), 1);
        chk(xferEnd == expEnd, "R6 read clock", 32'(xferEnd), 32'(expEnd));
        @(negedge clk);
        off += p;
      end
      off = 0;
      while (off < acc) begin
        int p = pieceLen(da + off, acc - off, bb);
        logic [31:0] expD = '0;
        logic [31:0] mask = '0;
        for (int i = 0; i < p; i++) begin
          expD[8*i +: 8] = mem[8'(sa + off + i)];
          mask[8*i +: 8] = 8'hFF;
        end
        chk(busWr && !busRd, "R1 write phase", {busRd, busWr}, 2'b01);
        chk(busAddr == 32'(da + off), "R4 write address", busAddr, 32'(da + off));
        chk(busLen == lenCode(p), "R4 write length", 32'(busLen), 32'(lenCode(p)));
        chk((busWdata & mask) == expD, "R1 write data", busWdata & mask, expD);
        chk(busReq, "R2 held in write", 32'(busReq), 1);
        chk(xferEnd == expEnd, "R6 write clock", 32'(xferEnd), 32'(expEnd));
        @(negedge clk);
        off += p;
      end
      chk(!busReq, "R2 released after pair", 32'(busReq), 0);
      busGrant = 1'b0;
      sa = stepBy(sa, sm, acc);
      da = stepBy(da, dm, acc);
    end
    chk(done == 1'b1, "R8 done after final", 32'(done), 1);
    readReg(2'd0, rd); chk(rd == 32'(sa), "R5 source after job", rd, 32'(sa));
    readReg(2'd1, rd); chk(rd == 32'(da), "R5 dest after job", rd, 32'(da));
    readReg(2'd2, rd); chk(rd == 0, "R8 count zero", rd, 0);
    readReg(2'd3, rd); chk(rd[0] == 1'b0 && rd[11], "R8 enable clear, done bit", rd, 32'h800);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    // R11: reset state
    for (int a = 0; a < 4; a++) begin
      readReg(2'(a), rd);
      chk(rd == 0, "R11 register reset", rd, 0);
    end
    chk({busReq, busRd, busWr, xferEnd, done} == 0, "R11 outputs low",
        {busReq, busRd, busWr, xferEnd, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R12: register map readback
    writeReg(2'd1, 32'h0000_00AB);
    readReg(2'd1, rd); chk(rd == 32'hAB, "R12 dest offset", rd, 32'hAB);
    writeReg(2'd3, 32'h0000_07FE);
    readReg(2'd3, rd); chk(rd == 32'h7FE, "R12 control bits", rd, 32'h7FE);

    runJob(8'h00, 8'h80, 3, 2'd1, 2'd1, 2'd2, 2'd2, 1'b0, 1'b1, 1'b0, 0);
    runJob(8'h11, 8'h90, 2, 2'd1, 2'd2, 2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 2);
    runJob(8'h21, 8'hA2, 2, 2'd1, 2'd0, 2'd2, 2'd2, 1'b0, 1'b0, 1'b1, 1);
    runJob(8'h30, 8'hB1, 3, 2'd2, 2'd1, 2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 1);
    runJob(8'h45, 8'hC3, 2, 2'd1, 2'd1, 2'd0, 2'd1, 1'b1, 1'b1, 1'b0, 3);
    runJob(8'h42, 8'hD0, 1, 2'd3, 2'd1, 2'd2, 2'd1, 1'b0, 1'b1, 1'b0, 0);

    // R10: enable with zero count
    writeReg(2'd2, 32'd0);
    writeReg(2'd3, 32'h0000_0001);
    for (int c = 0; c < 3; c++) begin
      chk(!busReq, "R10 no request at zero count", 32'(busReq), 0);
      @(negedge clk);
    end
    readReg(2'd3, rd);
    chk(rd[0] == 1'b0 && !rd[11], "R10 enable self-clears", rd, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule